// File: doc/BRIEF.md
# Word-Merging Write Cache

This block is a small direct-mapped cache that holds only writes. A write to a block with no frame takes the frame that the block maps to. Later writes to the same block land in that frame word by word, so several stores leave it as a single downstream transfer. Each word has one bit that means both "holds data" and "must be written back". A read lookup can hit on any word whose bit is set. A read that misses leaves the contents unchanged.

When a write maps to a frame that another block holds, the write port stalls. The old frame goes out on the eviction stream. The frame is cleared once the stream accepts the beat, and the write is accepted on the next cycle. A flush command walks every frame in index order, sends out each frame that holds data, clears it, and pulses done.

An invalidate port clears one word. A companion cache uses it so that a word never has two pending writes in the two structures. Coherence invalidations arriving from other processors have no path into the block.

Top module: `wcm_write_cache`

## Requirements
- R1: Addresses are word addresses. Bits [1:0] select the word, bits [4:2] select one of 8 frames, and the upper bits form the tag. A write to an empty frame is accepted in the cycle it is presented (wr_ready_o high). From the next cycle a read of that address hits and returns the written data.
- R2: Each word has one bit. A write sets the bit of its word and stores its data, and leaves the bits of the other words of the frame unchanged. A read of a word whose bit is clear misses and returns zero.
- R3: A write whose tag matches the resident block is accepted at once and merged into the frame, with no eviction beat. A repeated write to the same word replaces its data.
- R4: A write that maps to a frame holding another tag is stalled: wr_ready_o is low and ev_valid_o is high. This lasts until ev_ready_i accepts the old frame. The write is accepted in the following cycle, and after that the old block misses and the new word hits.
- R5: An eviction beat carries three things. ev_addr_o is the block address {tag, index}, which equals address bits [ADDR_W-1:2]. ev_mask_o bit w is set exactly for the words whose bit is set. Word w of ev_data_o is bits [32w+31:32w]; it holds the stored data for a set word and zero otherwise.
- R6: A read miss allocates nothing. Afterwards the same read still misses, and a write of another tag to that frame is accepted with no eviction.
- R7: rd_hit_o and rd_data_o answer in the same cycle from the current contents. rd_hit_o is low when rd_valid_i is low.
- R8: An invalidate clears the bit of one word, and only when the frame's tag matches. With a different tag it has no effect. A frame whose bits are all clear is free: a write of any tag to it is accepted without eviction. A write and an invalidate of the same word in the same cycle leave the word set with the new data.
- R9: A flush walks frames 0 to 7 in order. It emits one beat for each frame that holds data, with each beat held stable under backpressure, and clears each frame as its beat is accepted. flush_done_o is high for exactly one cycle, the cycle after the last frame is handled. wr_ready_o is low throughout the walk, and all frames are empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | WORD_W | Write data |
| wr_ready_o | output | 1 | Write accepted this cycle |
| rd_valid_i | input | 1 | Read lookup request |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_hit_o | output | 1 | Lookup hit a set word |
| rd_data_o | output | WORD_W | Word data on hit, zero on miss |
| inv_valid_i | input | 1 | Invalidate one word |
| inv_addr_i | input | ADDR_W | Word address to invalidate |
| flush_i | input | 1 | Start a flush walk |
| flush_done_o | output | 1 | One-cycle pulse at end of walk |
| ev_valid_o | output | 1 | Eviction beat valid |
| ev_ready_i | input | 1 | Downstream accepts eviction beat |
| ev_addr_o | output | ADDR_W-2 | Block address of the beat |
| ev_mask_o | output | WORDS | Set words in the beat |
| ev_data_o | output | WORDS*WORD_W | Block data, clean words zero |

## Verification
The bench keeps a frame model and expects eviction beats in order. It checks the following corner cases:
- A conflicting write under random backpressure. A design that accepts the write before the beat is taken would lose the old block.
- Reads that miss followed by writes of another tag. A design that allocates on a read would produce an extra eviction.
- Invalidates with a matching tag, invalidates with a different tag, and an invalidate that collides with a write to the same word. A design that ignores the tag, or lets the clear win, would lose data.
- Flushes over a mixed occupancy pattern and over an empty cache. Wrong walk order, beats for empty frames, or a done pulse of the wrong length would each show up.

// File: rtl/wcm_pkg.sv
`timescale 1ns/1ps
package wcm_pkg;
  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_WALK = 1'b1
  } flush_state_e;
endpackage

// File: rtl/wcm_frame_array.sv
`timescale 1ns/1ps
module wcm_frame_array #(
  parameter int FRAMES = 8,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 11
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       wr_en_i,
  input  logic [$clog2(FRAMES)-1:0]                  wr_idx_i,
  input  logic [$clog2(WORDS)-1:0]                   wr_off_i,
  input  logic [TAG_W-1:0]                           wr_tag_i,
  input  logic [WORD_W-1:0]                          wr_data_i,
  input  logic                                       clr_en_i,
  input  logic [$clog2(FRAMES)-1:0]                  clr_idx_i,
  input  logic                                       inv_en_i,
  input  logic [$clog2(FRAMES)-1:0]                  inv_idx_i,
  input  logic [$clog2(WORDS)-1:0]                   inv_off_i,
  output logic [FRAMES-1:0][TAG_W-1:0]               tag_o,
  output logic [FRAMES-1:0][WORDS-1:0]               mask_o,
  output logic [FRAMES-1:0][WORDS-1:0][WORD_W-1:0]   data_o
);
  logic [FRAMES-1:0][TAG_W-1:0]             tag_q;
  logic [FRAMES-1:0][WORDS-1:0]             mask_q;
  logic [FRAMES-1:0][WORDS-1:0][WORD_W-1:0] data_q;

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[f]  <= '0;
        mask_q[f] <= '0;
        data_q[f] <= '0;
      end else if (clr_en_i && clr_idx_i == f) begin
        mask_q[f] <= '0;
      end else begin
        if (inv_en_i && inv_idx_i == f) mask_q[f][inv_off_i] <= 1'b0;
        // later assignment: write wins over a same-word invalidate
        if (wr_en_i && wr_idx_i == f) begin
          mask_q[f][wr_off_i] <= 1'b1;
          tag_q[f]            <= wr_tag_i;
          data_q[f][wr_off_i] <= wr_data_i;
        end
      end
    end
  end

  assign tag_o  = tag_q;
  assign mask_o = mask_q;
  assign data_o = data_q;

  AST_WR_SETS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mask_q[$past(wr_idx_i)][$past(wr_off_i)]); // R2
  AST_WR_STORES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> data_q[$past(wr_idx_i)][$past(wr_off_i)] == $past(wr_data_i)); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> mask_q[$past(clr_idx_i)] == '0); // R4
endmodule

// File: rtl/wcm_flush_ctrl.sv
`timescale 1ns/1ps
module wcm_flush_ctrl
  import wcm_pkg::*;
#(
  parameter int FRAMES = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      cur_busy_i,
  input  logic                      ev_ready_i,
  output logic                      walk_o,
  output logic [$clog2(FRAMES)-1:0] idx_o,
  output logic                      done_o
);
  localparam int IDX_W = $clog2(FRAMES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  flush_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             step;

  assign step = !cur_busy_i || ev_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FL_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FL_IDLE: if (flush_i) begin
          state_q <= FL_WALK;
          idx_q   <= '0;
        end
        FL_WALK: if (step) begin
          if (idx_q == LAST) begin
            state_q <= FL_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= FL_IDLE;
      endcase
    end
  end

  assign walk_o = (state_q == FL_WALK);
  assign idx_o  = idx_q;
  assign done_o = done_q;

  AST_DONE_AFTER_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(walk_o) && !walk_o); // R9
  AST_WALK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_o && !cur_busy_i && idx_q != LAST |=> walk_o && idx_q == $past(idx_q) + 1'b1); // R9
  AST_WALK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_o && cur_busy_i && !ev_ready_i |=> walk_o && $stable(idx_q)); // R9
endmodule

// File: rtl/wcm_write_cache.sv
`timescale 1ns/1ps
module wcm_write_cache #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int FRAMES = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_valid_i,
  input  logic [ADDR_W-1:0]                     wr_addr_i,
  input  logic [WORD_W-1:0]                     wr_data_i,
  output logic                                  wr_ready_o,
  input  logic                                  rd_valid_i,
  input  logic [ADDR_W-1:0]                     rd_addr_i,
  output logic                                  rd_hit_o,
  output logic [WORD_W-1:0]                     rd_data_o,
  input  logic                                  inv_valid_i,
  input  logic [ADDR_W-1:0]                     inv_addr_i,
  input  logic                                  flush_i,
  output logic                                  flush_done_o,
  output logic                                  ev_valid_o,
  input  logic                                  ev_ready_i,
  output logic [ADDR_W-$clog2(WORDS)-1:0]       ev_addr_o,
  output logic [WORDS-1:0]                      ev_mask_o,
  output logic [WORDS*WORD_W-1:0]               ev_data_o
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(FRAMES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [FRAMES-1:0][TAG_W-1:0]             tag;
  logic [FRAMES-1:0][WORDS-1:0]             mask;
  logic [FRAMES-1:0][WORDS-1:0][WORD_W-1:0] data;
  logic [FRAMES-1:0]                        occ;

  logic [OFF_W-1:0] w_off, r_off, i_off;
  logic [IDX_W-1:0] w_idx, r_idx, i_idx, f_idx, ev_idx;
  logic [TAG_W-1:0] w_tag, r_tag, i_tag;
  logic w_conflict, wr_fire, ev_fire, evict_sel, inv_en, walk;

  assign w_off = wr_addr_i[OFF_W-1:0];
  assign w_idx = wr_addr_i[OFF_W +: IDX_W];
  assign w_tag = wr_addr_i[ADDR_W-1 -: TAG_W];
  assign r_off = rd_addr_i[OFF_W-1:0];
  assign r_idx = rd_addr_i[OFF_W +: IDX_W];
  assign r_tag = rd_addr_i[ADDR_W-1 -: TAG_W];
  assign i_off = inv_addr_i[OFF_W-1:0];
  assign i_idx = inv_addr_i[OFF_W +: IDX_W];
  assign i_tag = inv_addr_i[ADDR_W-1 -: TAG_W];

  for (genvar f = 0; f < FRAMES; f++) begin : g_occ
    assign occ[f] = |mask[f];
  end

  // write path: allocate on empty frame, merge on tag match, stall on conflict
  assign w_conflict = occ[w_idx] && (tag[w_idx] != w_tag);
  assign wr_ready_o = !walk && !w_conflict;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign evict_sel  = !walk && !flush_i && wr_valid_i && w_conflict;

  // eviction stream shared by conflict path and flush walk
  assign ev_idx     = walk ? f_idx : w_idx;
  assign ev_valid_o = evict_sel || (walk && occ[f_idx]);
  assign ev_fire    = ev_valid_o && ev_ready_i;
  assign ev_addr_o  = {tag[ev_idx], ev_idx};
  assign ev_mask_o  = mask[ev_idx];
  for (genvar w = 0; w < WORDS; w++) begin : g_evw
    assign ev_data_o[w*WORD_W +: WORD_W] = mask[ev_idx][w] ? data[ev_idx][w] : '0;
  end

  assign inv_en = inv_valid_i && (tag[i_idx] == i_tag);

  // read lookup, no allocation
  assign rd_hit_o  = rd_valid_i && mask[r_idx][r_off] && (tag[r_idx] == r_tag);
  assign rd_data_o = rd_hit_o ? data[r_idx][r_off] : '0;

  wcm_frame_array #(
    .FRAMES(FRAMES), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire),
    .wr_idx_i  (w_idx),
    .wr_off_i  (w_off),
    .wr_tag_i  (w_tag),
    .wr_data_i (wr_data_i),
    .clr_en_i  (ev_fire),
    .clr_idx_i (ev_idx),
    .inv_en_i  (inv_en),
    .inv_idx_i (i_idx),
    .inv_off_i (i_off),
    .tag_o     (tag),
    .mask_o    (mask),
    .data_o    (data)
  );

  wcm_flush_ctrl #(.FRAMES(FRAMES)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .cur_busy_i (occ[f_idx]),
    .ev_ready_i (ev_ready_i),
    .walk_o     (walk),
    .idx_o      (f_idx),
    .done_o     (flush_done_o)
  );

  AST_DONE_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> occ == '0); // R9
  AST_FIRE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_fire, ev_fire})); // R4
  AST_FLUSH_BEAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk && ev_valid_o && !ev_ready_i && !inv_valid_i
    |=> ev_valid_o && $stable(ev_addr_o) && $stable(ev_mask_o)); // R9
  AST_EVICT_FREES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_sel && ev_ready_i && !inv_valid_i |=> !w_conflict || !wr_valid_i
    || $changed(wr_addr_i)); // R4
endmodule

// File: tb/wcm_write_cache_bench.sv
`timescale 1ns/1ps
module wcm_write_cache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_valid = 0, rd_valid = 0, inv_valid = 0, flush = 0, ev_rdy = 1;
  logic [15:0] wr_addr = 0, rd_addr = 0, inv_addr = 0;
  logic [31:0] wr_data = 0;
  logic        wr_ready, rd_hit, flush_done, ev_valid;
  logic [31:0] rd_data;
  logic [13:0] ev_addr;
  logic [3:0]  ev_mask;
  logic [127:0] ev_data;

  wcm_write_cache u_wcm_write_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_hit_o(rd_hit), .rd_data_o(rd_data),
    .inv_valid_i(inv_valid), .inv_addr_i(inv_addr),
    .flush_i(flush), .flush_done_o(flush_done),
    .ev_valid_o(ev_valid), .ev_ready_i(ev_rdy), .ev_addr_o(ev_addr),
    .ev_mask_o(ev_mask), .ev_data_o(ev_data)
  );

  typedef struct packed {
    logic [13:0]  blk;
    logic [3:0]   mask;
    logic [127:0] data;
  } beat_t;

  beat_t exp_q[$];
  int vectors = 0, fails = 0;
  bit bp_mode = 0;
  int cyc = 0;

  logic [10:0] m_tag [8];
  logic [3:0]  m_mask[8];
  logic [31:0] m_data[8][4];

  function automatic logic [15:0] mk(int t, int i, int o);
    logic [10:0] tt = t[10:0];
    logic [2:0]  ii = i[2:0];
    logic [1:0]  oo = o[1:0];
    return {tt, ii, oo};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_frame(int f);
    beat_t b;
    b.blk  = {m_tag[f], f[2:0]};
    b.mask = m_mask[f];
    for (int w = 0; w < 4; w++)
      b.data[w*32 +: 32] = m_mask[f][w] ? m_data[f][w] : 32'h0;
    exp_q.push_back(b);
    m_mask[f] = 4'h0;
  endtask

  // backpressure source
  initial forever begin
    @(negedge clk);
    cyc++;
    ev_rdy = bp_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: compare accepted eviction beats against expected queue
  initial forever begin
    beat_t a, e;
    @(negedge clk); #1;
    if (rst_n && ev_valid && ev_rdy) begin
      a = '{blk: ev_addr, mask: ev_mask, data: ev_data};
      if (exp_q.size() == 0) begin
        chk(0, "R5", "unexpected eviction beat", 160'(a), 160'(0));
      end else begin
        e = exp_q.pop_front();
        chk(a == e, "R5", "eviction beat", 160'(a), 160'(e));
      end
    end
  end

  task automatic wr_inv(logic [15:0] a, logic [31:0] d, bit with_inv);
    int idx = a[4:2], off = a[1:0], stall = 0;
    logic [10:0] t = a[15:5];
    bit exp_stall = (m_mask[idx] != 0) && (m_tag[idx] != t);
    if (exp_stall) push_frame(idx);
    m_mask[idx][off] = 1'b1;
    m_tag[idx] = t;
    m_data[idx][off] = d;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    if (with_inv) begin inv_valid = 1; inv_addr = a; end
    #1;
    if (!wr_ready) chk(ev_valid, "R4", "ev_valid during stall", 160'(ev_valid), 160'(1));
    while (!wr_ready && stall < 100) begin
      stall++;
      @(negedge clk); #1;
    end
    if (exp_stall) chk(stall > 0, "R4", "conflict write stalled", 160'(stall), 160'(1));
    else chk(stall == 0, "R3", "write accepted at once", 160'(stall), 160'(0));
    @(negedge clk);
    wr_valid = 0; inv_valid = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    wr_inv(a, d, 0);
  endtask

  task automatic rd(logic [15:0] a, string req);
    int idx = a[4:2], off = a[1:0];
    bit eh = m_mask[idx][off] && (m_tag[idx] == a[15:5]);
    logic [31:0] ed = eh ? m_data[idx][off] : 32'h0;
    @(negedge clk);
    rd_valid = 1; rd_addr = a;
    #1;
    chk(rd_hit == eh && rd_data == ed, req, "read lookup",
        160'({rd_hit, rd_data}), 160'({eh, ed}));
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic inv(logic [15:0] a);
    int idx = a[4:2], off = a[1:0];
    if (m_tag[idx] == a[15:5]) m_mask[idx][off] = 1'b0;
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic do_flush();
    int n = 0;
    for (int f = 0; f < 8; f++) if (m_mask[f] != 0) push_frame(f);
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    #1;
    chk(!wr_ready, "R9", "write port held during walk", 160'(wr_ready), 160'(0));
    while (!flush_done && n < 300) begin
      n++;
      @(negedge clk); #1;
    end
    chk(flush_done, "R9", "flush done seen", 160'(flush_done), 160'(1));
    @(negedge clk); #1;
    chk(!flush_done, "R9", "done is one cycle", 160'(flush_done), 160'(0));
    chk(exp_q.size() == 0, "R9", "all flush beats emitted", 160'(exp_q.size()), 160'(0));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    report();
    $finish;
  end

  initial begin
    for (int f = 0; f < 8; f++) begin
      m_tag[f] = 0; m_mask[f] = 0;
      for (int w = 0; w < 4; w++) m_data[f][w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(wr_ready && !ev_valid && !flush_done && !rd_hit, "R1", "reset state",
        160'({wr_ready, ev_valid, flush_done, rd_hit}), 160'(4'b1000));

    // R1 allocate, R2 per-word bits
    wr(mk(1, 0, 0), 32'h1111_0000);
    rd(mk(1, 0, 0), "R1");
    rd(mk(1, 0, 1), "R2");
    // R3 merge and overwrite
    wr(mk(1, 0, 2), 32'h1111_0002);
    wr(mk(1, 0, 0), 32'h1111_00AA);
    rd(mk(1, 0, 0), "R3");
    rd(mk(1, 0, 2), "R3");
    // R7 read with valid low
    @(negedge clk); rd_addr = mk(1, 0, 0); rd_valid = 0; #1;
    chk(!rd_hit, "R7", "no hit without valid", 160'(rd_hit), 160'(0));
    // R6 read miss does not allocate
    rd(mk(5, 3, 0), "R6");
    wr(mk(6, 3, 1), 32'h6666_0001);
    rd(mk(5, 3, 0), "R6");
    rd(mk(6, 3, 1), "R6");
    // R4 conflict eviction
    wr(mk(2, 0, 3), 32'h2222_0003);
    rd(mk(1, 0, 0), "R4");
    rd(mk(2, 0, 3), "R4");
    // R8 invalidate
    wr(mk(7, 5, 0), 32'h7777_0000);
    wr(mk(7, 5, 2), 32'h7777_0002);
    inv(mk(7, 5, 2));
    rd(mk(7, 5, 2), "R8");
    inv(mk(8, 5, 0));
    rd(mk(7, 5, 0), "R8");
    inv(mk(7, 5, 0));
    wr(mk(9, 5, 1), 32'h9999_0001);
    rd(mk(9, 5, 1), "R8");
    wr_inv(mk(9, 5, 3), 32'h9999_0003, 1);
    rd(mk(9, 5, 3), "R8");
    // R4 under backpressure
    bp_mode = 1;
    wr(mk(3, 0, 1), 32'h3333_0001);
    rd(mk(3, 0, 1), "R4");
    // R9 flush with backpressure
    do_flush();
    rd(mk(3, 0, 1), "R9");
    rd(mk(6, 3, 1), "R9");
    rd(mk(9, 5, 1), "R9");
    // R9 empty flush
    bp_mode = 0;
    do_flush();
    // mixed pattern
    bp_mode = 1;
    for (int k = 0; k < 24; k++)
      wr(mk((k % 3) + 1, (k * 3) % 8, (k + k / 4) % 4), 32'hA000_0000 + k * 17);
    for (int k = 0; k < 8; k++) rd(mk(3, k, k % 4), "R2");
    do_flush();
    bp_mode = 0;
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "no beats outstanding", 160'(exp_q.size()), 160'(0));
    report();
    $finish;
  end
endmodule